// File: doc/BRIEF.md
# SDRAM Command and Timing Controller

This block turns single-word read and write requests from a valid/ready port into the command stream of a four-bank synchronous DRAM. Each request opens a row with ACTIVE, then issues READ or WRITE with auto-precharge. The block spaces every command by cycle counts. These counts come from nanosecond minimums at a fixed clock period, 7.5 ns by default. Read data comes back on a one-cycle strobe, aligned to the programmed CAS latency.

After reset the controller waits out a power-up delay. It then closes all banks, runs two refresh cycles and writes the mode register, and only then accepts requests. From then on, an internal interval timer requests an AUTO REFRESH. A pending refresh wins over a new request, but it never splits an access that is already under way. The user address is laid out as {bank, row, column}. The bank goes to the bank-address pins, the row goes to the address pins with ACTIVE, and the column goes out with READ or WRITE.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is asserted, the command pins {cs_n, ras_n, cas_n, we_n} read 0111 (NOP), and req_ready, rd_valid and sd_dq_oe are 0.
- R2: After the power-up delay, the first four non-NOP commands are, in this order: PRECHARGE with A10=1, AUTO REFRESH, AUTO REFRESH, LOAD MODE. The gaps between them are at least 3, 9 and 9 cycles. req_ready stays 0 until LOAD MODE has been issued.
- R3: LOAD MODE drives bank address 0 and an address with A[6:4] = 3 when cas_lat_3 is 1, or 2 when it is 0. All other address bits are 0 (burst of one, sequential).
- R4: Command codes on {cs_n, ras_n, cas_n, we_n} are: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000.
- R5: An accepted request produces ACTIVE with BA = addr[21:20] and A = addr[19:8]. Exactly 3 cycles later comes READ or WRITE to the same bank, with A[7:0] = addr[7:0], A10 = 1 and all other address bits 0.
- R6: Between an ACTIVE or AUTO REFRESH and the next ACTIVE or AUTO REFRESH there are at least 9 cycles.
- R7: sd_dq_oe is 1 exactly in the cycle in which the WRITE command is on the pins, and sd_dq_out then equals the request's write data.
- R8: For each READ, rd_valid pulses for one cycle. It is high in the cycle that starts at the rising edge CL cycles after the edge that sampled READ (CL = 3 or 2 per cas_lat_3). rd_data then holds the DQ value sampled on that edge.
- R9: After initialisation, successive AUTO REFRESH commands are between 2083-12 and 2083+12 cycles apart.
- R10: A refresh comes ahead of waiting requests, so refresh keeps its interval under back-to-back requests. No command other than NOP ever falls between an ACTIVE and its READ or WRITE.
- R11: A request is taken on a clock edge with req_valid and req_ready both 1. req_ready is 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all pins change and are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cas_lat_3 | input | 1 | CAS latency choice taken at LOAD MODE: 1 selects 3, 0 selects 2 |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank[21:20], row[19:8], column[7:0]} |
| req_wdata | input | 16 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 16 | Read data |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_a | output | 12 | Multiplexed row/column/mode address; bit 10 is the precharge select |
| sd_dq_out | output | 16 | Data driven to the memory |
| sd_dq_oe | output | 1 | Output enable for sd_dq_out |
| sd_dq_in | input | 16 | Data returned from the memory |

## Verification
A wrong state register or wait counter shows up on the command pins within one command slot. The spacing between ACTIVE and its column command moves off 3, a row cycle shrinks below 9, or a stray command lands inside an open access. A mis-tapped latency pipeline makes rd_valid arrive one cycle early or late against the READ, and the data returned is the memory model's idle pattern instead of the stored word. A stuck refresh timer or lost pending flag shows up only at the next refresh interval, about two thousand cycles later, as a gap outside the allowed window.

// File: rtl/sdram_cmd_pkg.sv
package sdram_cmd_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_NOP = 4'b0111
  } sdram_cmd_e;

  typedef enum logic [2:0] {
    ST_WAIT, ST_PRE, ST_REF1, ST_REF2, ST_MRS, ST_IDLE, ST_RW
  } ctrl_state_e;

  function automatic int unsigned cyc_ceil(int unsigned ps, int unsigned clk_ps);
    return (ps + clk_ps - 1) / clk_ps;
  endfunction

  function automatic int unsigned cyc_floor(int unsigned ps, int unsigned clk_ps);
    return ps / clk_ps;
  endfunction

endpackage

// File: rtl/sdram_refresh_timer.sv
module sdram_refresh_timer #(
  parameter int unsigned INTERVAL = 2083
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic ack,
  output logic pending
);
  localparam int unsigned CW = $clog2(INTERVAL + 1);

  logic [CW-1:0] cnt_q, cnt_n;
  logic          pend_n;
  logic          wrap;

  assign wrap = (cnt_q == CW'(INTERVAL - 1));

  always_comb begin
    cnt_n  = cnt_q;
    pend_n = pending;
    if (run) cnt_n = wrap ? '0 : cnt_q + 1'b1;
    if (ack) pend_n = 1'b0;
    if (run && wrap) pend_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      pending <= 1'b0;
    end else begin
      cnt_q   <= cnt_n;
      pending <= pend_n;
    end
  end

  // R9: an acknowledged refresh leaves no request behind
  a_r9_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !pending);

endmodule

// File: rtl/sdram_rd_capture.sv
module sdram_rd_capture #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned MAX_CL = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_issue,
  input  logic              cl3,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);
  logic [MAX_CL-1:0] pipe_q;
  logic              tap;

  // pipe_q[k] set means READ was sampled k+1 edges ago
  assign tap = cl3 ? pipe_q[MAX_CL-1] : pipe_q[MAX_CL-2];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pipe_q   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      pipe_q   <= {pipe_q[MAX_CL-2:0], rd_issue};
      rd_valid <= tap;
      if (tap) rd_data <= dq_in;
    end
  end

  // R8: reads are a full row cycle apart, so the strobe is a single pulse
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid);

endmodule

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_cmd_pkg::*;
#(
  parameter int unsigned CLK_PS     = 7500,
  parameter int unsigned TRCD_PS    = 20000,
  parameter int unsigned TRP_PS     = 20000,
  parameter int unsigned TRC_PS     = 67500,
  parameter int unsigned REFI_PS    = 15_625_000,
  parameter int unsigned POWERUP_PS = 100_000_000,
  parameter int unsigned BANK_W     = 2,
  parameter int unsigned ROW_W      = 12,
  parameter int unsigned COL_W      = 8,
  parameter int unsigned DATA_W     = 16
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            cas_lat_3,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rd_valid,
  output logic [DATA_W-1:0]               rd_data,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a,
  output logic [DATA_W-1:0]               sd_dq_out,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_in
);
  localparam int unsigned ADDR_W  = BANK_W + ROW_W + COL_W;
  localparam int unsigned TRCD_C  = cyc_ceil(TRCD_PS, CLK_PS);
  localparam int unsigned TRP_C   = cyc_ceil(TRP_PS, CLK_PS);
  localparam int unsigned TRC_C   = cyc_ceil(TRC_PS, CLK_PS);
  localparam int unsigned TMRD_C  = 2;
  localparam int unsigned PWR_C   = cyc_ceil(POWERUP_PS, CLK_PS);
  localparam int unsigned REFI_C  = cyc_floor(REFI_PS, CLK_PS);
  localparam int unsigned CNT_MAX = (PWR_C > TRC_C) ? PWR_C : TRC_C;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);
  localparam int unsigned PRE_BIT = 10;
  localparam int unsigned SINCE_W = $clog2(TRC_C + 1);

  // synchronous release of the asynchronous reset
  logic [1:0] rst_sync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  ctrl_state_e              state_q, state_n, ret_q, ret_n;
  logic [CNT_W-1:0]         cnt_q, cnt_n;
  sdram_cmd_e               cmd_q, cmd_n;
  logic [BANK_W-1:0]        ba_n;
  logic [ROW_W-1:0]         a_n;
  logic [DATA_W-1:0]        dqo_n, wdata_q, wdata_n;
  logic                     oe_n, we_q, we_n, cl3_q, cl3_n, init_done_q, init_done_n;
  logic [COL_W-1:0]         col_q, col_n;
  logic                     ref_pend, ref_ack;

  assign req_ready = (state_q == ST_IDLE) && !ref_pend;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd_q;

  always_comb begin
    state_n     = state_q;
    ret_n       = ret_q;
    cnt_n       = cnt_q;
    cmd_n       = CMD_NOP;
    ba_n        = sd_ba;
    a_n         = sd_a;
    dqo_n       = sd_dq_out;
    oe_n        = 1'b0;
    we_n        = we_q;
    col_n       = col_q;
    wdata_n     = wdata_q;
    cl3_n       = cl3_q;
    init_done_n = init_done_q;
    ref_ack     = 1'b0;
    unique case (state_q)
      ST_WAIT: begin
        if (cnt_q == '0) state_n = ret_q;
        else             cnt_n   = cnt_q - 1'b1;
      end
      ST_PRE: begin
        cmd_n = CMD_PRE;
        a_n = '0; a_n[PRE_BIT] = 1'b1;
        state_n = ST_WAIT; cnt_n = CNT_W'(TRP_C - 2); ret_n = ST_REF1;
      end
      ST_REF1: begin
        cmd_n = CMD_REF;
        state_n = ST_WAIT; cnt_n = CNT_W'(TRC_C - 2); ret_n = ST_REF2;
      end
      ST_REF2: begin
        cmd_n = CMD_REF;
        state_n = ST_WAIT; cnt_n = CNT_W'(TRC_C - 2); ret_n = ST_MRS;
      end
      ST_MRS: begin
        cmd_n = CMD_MRS;
        ba_n = '0;
        a_n = '0; a_n[6:4] = cas_lat_3 ? 3'd3 : 3'd2;
        cl3_n = cas_lat_3;
        init_done_n = 1'b1;
        state_n = ST_WAIT; cnt_n = CNT_W'(TMRD_C - 2); ret_n = ST_IDLE;
      end
      ST_IDLE: begin
        if (ref_pend) begin
          cmd_n = CMD_REF;
          ref_ack = 1'b1;
          state_n = ST_WAIT; cnt_n = CNT_W'(TRC_C - 2); ret_n = ST_IDLE;
        end else if (req_valid) begin
          cmd_n   = CMD_ACT;
          ba_n    = req_addr[ADDR_W-1 -: BANK_W];
          a_n     = req_addr[COL_W +: ROW_W];
          we_n    = req_write;
          col_n   = req_addr[0 +: COL_W];
          wdata_n = req_wdata;
          state_n = ST_WAIT; cnt_n = CNT_W'(TRCD_C - 2); ret_n = ST_RW;
        end
      end
      ST_RW: begin
        cmd_n = we_q ? CMD_WR : CMD_RD;
        a_n = '0; a_n[COL_W-1:0] = col_q; a_n[PRE_BIT] = 1'b1;
        oe_n  = we_q;
        dqo_n = wdata_q;
        state_n = ST_WAIT; cnt_n = CNT_W'(TRC_C - TRCD_C - 2); ret_n = ST_IDLE;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_WAIT;
      ret_q       <= ST_PRE;
      cnt_q       <= CNT_W'(PWR_C - 1);
      cmd_q       <= CMD_NOP;
      sd_ba       <= '0;
      sd_a        <= '0;
      sd_dq_out   <= '0;
      sd_dq_oe    <= 1'b0;
      we_q        <= 1'b0;
      col_q       <= '0;
      wdata_q     <= '0;
      cl3_q       <= 1'b0;
      init_done_q <= 1'b0;
    end else begin
      state_q     <= state_n;
      ret_q       <= ret_n;
      cnt_q       <= cnt_n;
      cmd_q       <= cmd_n;
      sd_ba       <= ba_n;
      sd_a        <= a_n;
      sd_dq_out   <= dqo_n;
      sd_dq_oe    <= oe_n;
      we_q        <= we_n;
      col_q       <= col_n;
      wdata_q     <= wdata_n;
      cl3_q       <= cl3_n;
      init_done_q <= init_done_n;
    end
  end

  sdram_refresh_timer #(.INTERVAL(REFI_C)) u_refresh (
    .clk(clk), .rst_n(rst_ni), .run(init_done_q), .ack(ref_ack), .pending(ref_pend)
  );

  sdram_rd_capture #(.DATA_W(DATA_W), .MAX_CL(3)) u_capture (
    .clk(clk), .rst_n(rst_ni), .rd_issue(cmd_q == CMD_RD), .cl3(cl3_q),
    .dq_in(sd_dq_in), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  // Independent spacing observers for the checks below
  logic [SINCE_W-1:0] since_act_q, since_row_q;
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      since_act_q <= SINCE_W'(TRC_C);
      since_row_q <= SINCE_W'(TRC_C);
    end else begin
      if (cmd_q == CMD_ACT)                   since_act_q <= SINCE_W'(1);
      else if (since_act_q != SINCE_W'(TRC_C)) since_act_q <= since_act_q + 1'b1;
      if (cmd_q == CMD_ACT || cmd_q == CMD_REF) since_row_q <= SINCE_W'(1);
      else if (since_row_q != SINCE_W'(TRC_C)) since_row_q <= since_row_q + 1'b1;
    end
  end

  // R5: column command exactly tRCD after its ACTIVE
  a_r5_trcd: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q == CMD_RD || cmd_q == CMD_WR) |-> since_act_q == SINCE_W'(TRCD_C));
  // R6: row cycle respected between ACTIVE/REFRESH commands
  a_r6_trc: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_q == CMD_ACT || cmd_q == CMD_REF) |-> since_row_q == SINCE_W'(TRC_C));
  // R7: data driven only alongside WRITE
  a_r7_oe_write: assert property (@(posedge clk) disable iff (!rst_ni)
    sd_dq_oe |-> cmd_q == CMD_WR);
  // R11: an accepted request closes the port for the next cycle
  a_r11_busy: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready) |=> !req_ready);
  // R2: no request taken before the mode register is written
  a_r2_ready_after_init: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> init_done_q);

endmodule

// File: tb/sdram_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module sdram_cmd_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TRCD = 3, TRP = 3, TRC = 9, REFI = 2083;
  localparam int NV = 8;
  localparam logic [NV-1:0] V_WE = 8'b0001_0111; // bit i = entry i is a write
  localparam logic [21:0] V_ADDR [NV] = '{
    {2'd0, 12'h005, 8'h03}, {2'd3, 12'hFFF, 8'hFF}, {2'd1, 12'h007, 8'h00},
    {2'd0, 12'h005, 8'h03}, {2'd2, 12'h001, 8'h09}, {2'd3, 12'hFFF, 8'hFF},
    {2'd1, 12'h007, 8'h00}, {2'd2, 12'h001, 8'h09}};
  localparam logic [15:0] V_DATA [NV] = '{
    16'h1234, 16'hABCD, 16'h00FF, 16'h1234, 16'h5A5A, 16'hABCD, 16'h00FF, 16'h5A5A};

  logic clk = 1'b0, rst_n, cas_lat_3, req_valid, req_write, req_ready, rd_valid;
  logic [21:0] req_addr;
  logic [15:0] req_wdata, rd_data, sd_dq_out, sd_dq_in;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_a;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_cmd_ctrl #(.POWERUP_PS(750_000)) u_sdram_cmd_ctrl (
    .clk(clk), .rst_n(rst_n), .cas_lat_3(cas_lat_3), .req_valid(req_valid),
    .req_ready(req_ready), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rd_valid(rd_valid), .rd_data(rd_data),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_a(sd_a), .sd_dq_out(sd_dq_out), .sd_dq_oe(sd_dq_oe),
    .sd_dq_in(sd_dq_in));

  int tests = 0, fails = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // behavioural memory
  logic [15:0] mem [1024];
  logic [11:0] open_row [4];
  logic [2:0]  m_cl;
  logic        m_pend;
  logic [1:0]  m_cnt;
  logic [15:0] m_word;
  wire [3:0] pins = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
  function automatic int idx(input logic [1:0] b, input logic [11:0] r, input logic [7:0] c);
    return {b, r[3:0], c[3:0]};
  endfunction
  always @(posedge clk) begin
    if (m_pend) begin
      if (m_cnt == 2'd1) begin sd_dq_in <= m_word; m_pend <= 1'b0; end
      else m_cnt <= m_cnt - 2'd1;
    end else sd_dq_in <= 16'hDEAD;
    case (pins)
      4'b0000: m_cl <= sd_a[6:4];
      4'b0011: open_row[sd_ba] <= sd_a;
      4'b0100: mem[idx(sd_ba, open_row[sd_ba], sd_a[7:0])] <= sd_dq_out;
      4'b0101: begin
        m_word <= mem[idx(sd_ba, open_row[sd_ba], sd_a[7:0])];
        m_pend <= 1'b1;
        m_cnt  <= 2'(m_cl - 3'd1);
      end
      default: ;
    endcase
  end

  // expectations set by the driver
  logic [1:0]  e_ba;
  logic [11:0] e_row;
  logic [7:0]  e_col;
  logic [15:0] e_wdata, e_rdata;
  int reads_req = 0, reads_seen = 0;

  // pin monitor, sampled mid-cycle
  int init_idx, last_cmd_n, last_row_n, last_act_n, last_rd_n, last_ref_n, post_refs;
  bit act_open, early_ready;
  always @(negedge clk) begin
    if (!rst_n) begin
      init_idx = 0; last_cmd_n = -1000; last_row_n = -1000; last_act_n = -1000;
      last_rd_n = -1000; last_ref_n = -1000; post_refs = 0; act_open = 0; early_ready = 0;
    end else begin
      if (init_idx < 4 && req_ready) early_ready = 1;
      if (sd_dq_oe && pins != 4'b0100) chk(0, "R7 oe outside WRITE", pins, 4'b0100);
      if (pins != 4'b0111) begin
        if (act_open && pins != 4'b0101 && pins != 4'b0100)
          chk(0, "R10 command inside access", pins, 4'b0111);
        if (init_idx < 4) begin
          case (init_idx)
            0: chk(pins == 4'b0010 && sd_a[10], "R2 init PRECHARGE-all", {pins, sd_a}, {4'b0010, 12'h400});
            1: chk(pins == 4'b0001 && cyc - last_cmd_n >= TRP, "R2 init REFRESH 1", cyc - last_cmd_n, TRP);
            2: chk(pins == 4'b0001 && cyc - last_cmd_n >= TRC, "R2 init REFRESH 2", cyc - last_cmd_n, TRC);
            default: begin
              chk(pins == 4'b0000 && cyc - last_cmd_n >= TRC, "R2 init LOAD MODE", {pins, 12'(cyc - last_cmd_n)}, {4'b0000, 12'(TRC)});
              chk(sd_ba == 0 && sd_a == (cas_lat_3 ? 12'h030 : 12'h020), "R3 mode word",
                  {sd_ba, sd_a}, cas_lat_3 ? 12'h030 : 12'h020);
              chk(!early_ready, "R2 ready before LOAD MODE", early_ready, 0);
            end
          endcase
          init_idx++;
          if (pins == 4'b0001) last_row_n = cyc;
        end else begin
          case (pins)
            4'b0011: begin
              chk(cyc - last_row_n >= TRC, "R6 ACTIVE spacing", cyc - last_row_n, TRC);
              chk(sd_ba == e_ba && sd_a == e_row, "R5 ACTIVE bank/row", {sd_ba, sd_a}, {e_ba, e_row});
              act_open = 1; last_act_n = cyc; last_row_n = cyc;
            end
            4'b0101, 4'b0100: begin
              chk(act_open && cyc - last_act_n == TRCD, "R5 tRCD", cyc - last_act_n, TRCD);
              chk(sd_ba == e_ba && sd_a == {4'b0100, e_col}, "R5 column address", {sd_ba, sd_a}, {e_ba, 4'b0100, e_col});
              if (pins == 4'b0100)
                chk(sd_dq_oe && sd_dq_out == e_wdata, "R7 write data", {sd_dq_oe, sd_dq_out}, {1'b1, e_wdata});
              else last_rd_n = cyc;
              act_open = 0;
            end
            4'b0001: begin
              chk(cyc - last_row_n >= TRC, "R6 REFRESH spacing", cyc - last_row_n, TRC);
              if (post_refs > 0)
                chk(cyc - last_ref_n >= REFI - 12 && cyc - last_ref_n <= REFI + 12,
                    "R9 refresh interval", cyc - last_ref_n, REFI);
              post_refs++; last_ref_n = cyc; last_row_n = cyc;
            end
            default: chk(0, "R4 unexpected command", pins, 4'b0111);
          endcase
        end
        last_cmd_n = cyc;
      end
      if (rd_valid) begin
        reads_seen++;
        chk(cyc - last_rd_n == (cas_lat_3 ? 4 : 3), "R8 read latency", cyc - last_rd_n, cas_lat_3 ? 4 : 3);
        chk(rd_data == e_rdata, "R8 read data", rd_data, e_rdata);
      end
    end
  end

  task automatic request(input logic we, input logic [21:0] addr, input logic [15:0] data);
    int guard = 0;
    @(negedge clk);
    while (!req_ready && guard < 200) begin @(negedge clk); guard++; end
    e_ba = addr[21:20]; e_row = addr[19:8]; e_col = addr[7:0];
    if (we) e_wdata = data; else begin e_rdata = data; reads_req++; end
    req_valid = 1; req_write = we; req_addr = addr; req_wdata = data;
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
    chk(!req_ready, "R11 ready drops after accept", req_ready, 0);
    repeat (10) @(negedge clk);
  endtask

  task automatic do_reset(input logic cl3);
    rst_n = 0; cas_lat_3 = cl3; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(pins == 4'b0111 && !req_ready && !rd_valid && !sd_dq_oe, "R1 reset state",
        {pins, req_ready, rd_valid, sd_dq_oe}, {4'b0111, 3'b000});
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(pins == 4'b0111 && !req_ready, "R1 quiet during power-up", {pins, req_ready}, {4'b0111, 1'b0});
    while (!req_ready) @(negedge clk);
    chk(init_idx == 4, "R2 init complete before ready", init_idx, 4);
  endtask

  initial begin
    repeat (150_000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    m_pend = 0; m_cl = 3'd3; sd_dq_in = 16'hDEAD;
    do_reset(1'b1);
    for (int i = 0; i < NV; i++) request(V_WE[i], V_ADDR[i], V_DATA[i]);
    chk(reads_seen == reads_req, "R8 one strobe per read", reads_seen, reads_req);
    // back-to-back stress across several refresh intervals (R9, R10)
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      while (!req_ready) @(negedge clk);
      e_ba = 2'd1; e_row = 12'h0C0; e_col = 8'h21; e_wdata = 16'(i);
      req_valid = 1; req_write = 1; req_addr = {2'd1, 12'h0C0, 8'h21}; req_wdata = 16'(i);
      @(posedge clk);
    end
    @(negedge clk); req_valid = 0;
    chk(post_refs >= 2, "R10 refresh served under load", post_refs, 2);
    request(1'b0, {2'd1, 12'h0C0, 8'h21}, 16'd499);
    // second run at CAS latency 2
    do_reset(1'b0);
    reads_seen = 0; reads_req = 0;
    request(1'b0, V_ADDR[2], V_DATA[2]);
    request(1'b1, V_ADDR[4], 16'hC3C3);
    request(1'b0, V_ADDR[4], 16'hC3C3);
    chk(reads_seen == reads_req, "R8 strobes at latency 2", reads_seen, reads_req);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule